// File: doc/BRIEF.md
# Serial Capacitor Trim Word Controller

This block is the digital side of a trimmable capacitor array. A serial clock and a serial data line load an 11-bit trim word into a shift register. The block also holds a behavioural model of an 11-bit nonvolatile store. Ten bank-select lines leave the block as three binary fields: a 2-bit high bank, a 3-bit middle bank and a 5-bit low bank. The static level of the serial clock decides which word drives these lines. When the clock is high, the live shift register drives them and a 1 selects a capacitor. When the clock is low, the stored word drives them and a 0 selects a capacitor.

A programming-voltage indication acts on its rising edge. If the shifted word is all ones, the edge erases the store. Otherwise the edge clears every stored bit whose shifted bit is 0. To read back a stored bit, shift a 0 into its position and then hold both data and clock high. A readback output with its own enable then presents that bit.

All pins are sampled in a single system clock domain. The nominal array value is 6.6 pF fixed, plus 6.4 pF per high-bank step, 1.4 pF per middle-bank step and 0.063 pF per low-bank step.

Top module: `cap_trim_ctrl`

## Requirements
- R1: A rising edge of `sclk`, seen at a system clock edge, shifts `sdat` into the word from the top. After 11 such edges, the first bit sent sits in bit 0 and the last bit sent sits in bit 10.
- R2: While `sclk` is high, the selects follow the shift register directly, with 1 meaning selected: `sel_hi` = bits 10:9, `sel_mid` = bits 8:6, `sel_lo` = bits 5:1, each with the higher bit more significant. Bit 0 affects no select.
- R3: While `sclk` is low, the selects take the inverse of the stored word's bits 10:1, so a stored 0 selects a capacitor.
- R4: After reset the shift register is all zeros and the store is all ones, so with `sclk` low every select is 0 and `rb_oe` is 0.
- R5: A rising edge of `hv_pulse` while the shift register is all ones sets every stored bit to 1, including bit 0.
- R6: Any other rising edge of `hv_pulse` clears each stored bit whose shift-register bit is 0 and leaves all other stored bits unchanged. No stored bit is ever set by this write.
- R7: `rb_oe` is 1 only while `sclk` and `sdat` are both high, `hv_pulse` is low and the shift register holds at least one 0. `rb_data` then equals the stored bit at the lowest 0 position of the shift register. Otherwise `rb_data` is 0.
- R8: Holding `hv_pulse` high does not write again. The store changes only on the rising edge of `hv_pulse`.
- R9: The word 00000010100 (bits 2 and 4 set, written bit 10 first) decodes to low bank 10 and nothing else, which is 7.23 pF nominal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset (fresh-part state) |
| sclk | input | 1 | Serial clock; its static level selects the select source |
| sdat | input | 1 | Serial data |
| hv_pulse | input | 1 | Programming voltage present; rising edge writes or erases |
| sel_hi | output | 2 | High bank select code |
| sel_mid | output | 3 | Middle bank select code |
| sel_lo | output | 5 | Low bank select code |
| rb_data | output | 1 | Selected stored bit during readback |
| rb_oe | output | 1 | Readback output enable (driver active) |

## Verification
The bench loads words that differ only in bit 0. A design that decoded bit 0 would then move a select. It also loads words with lopsided fields, which expose a reversed shift direction or swapped field boundaries. The bench programs the store and checks that the clock-low selects come out inverted; a design that used the stored polarity unchanged would select the complement. It holds the programming input high across a new shift, so a level-triggered write would clear an extra bit. It also checks that erase restores bit 0 and that readback is disabled when data is low or when no position is chosen.

// File: rtl/cap_trim_ctrl.sv
module cap_trim_ctrl #(
  parameter int W     = 11,
  parameter int HI_W  = 2,
  parameter int MID_W = 3,
  parameter int LO_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             sdat,
  input  logic             hv_pulse,
  output logic [HI_W-1:0]  sel_hi,
  output logic [MID_W-1:0] sel_mid,
  output logic [LO_W-1:0]  sel_lo,
  output logic             rb_data,
  output logic             rb_oe
);
  localparam int LO_LSB  = 1;
  localparam int MID_LSB = LO_LSB + LO_W;
  localparam int HI_LSB  = MID_LSB + MID_W;
  localparam int IW      = $clog2(W);

  logic [W-1:0]  sr, store, src;
  logic          sclk_q, hv_q;
  logic [IW-1:0] pick;
  logic          found;

  wire sclk_rise = sclk & ~sclk_q;
  wire hv_rise   = hv_pulse & ~hv_q;

  always_ff @(posedge clk) begin
    sclk_q <= sclk;
    hv_q   <= hv_pulse;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         sr <= '0;
    else if (sclk_rise) sr <= {sdat, sr[W-1:1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       store <= '1;
    else if (hv_rise) store <= (&sr) ? '1 : (store & sr);

  assign src     = sclk ? sr : ~store;
  assign sel_hi  = src[HI_LSB  +: HI_W];
  assign sel_mid = src[MID_LSB +: MID_W];
  assign sel_lo  = src[LO_LSB  +: LO_W];

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = W - 1; i >= 0; i--)
      if (!sr[i]) begin
        pick  = IW'(i);
        found = 1'b1;
      end
  end

  assign rb_oe   = sclk & sdat & ~hv_pulse & found;
  assign rb_data = rb_oe & store[pick];
endmodule

// File: rtl/cap_trim_chk.sv
module cap_trim_chk #(
  parameter int W = 11
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sclk,
  input logic         sdat,
  input logic         hv_pulse,
  input logic         rb_oe,
  input logic [W-1:0] sr,
  input logic [W-1:0] store,
  input logic [W-2:0] sel
);
  a_r1_shift: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |=> sr == {$past(sdat), $past(sr[W-1:1])});

  a_r3_stored_inverted: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk |-> sel == ~store[W-1:1]);

  a_r5_erase: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hv_pulse) && (&sr)) |=> (&store));

  a_r6_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(hv_pulse) && (&sr)) |=> ((store & ~$past(store)) == '0));

  a_r8_level_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(hv_pulse) |=> $stable(store));

  a_r7_oe_cond: assert property (@(posedge clk) disable iff (!rst_n)
    rb_oe |-> (sclk && sdat && !hv_pulse));
endmodule

bind cap_trim_ctrl cap_trim_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdat(sdat), .hv_pulse(hv_pulse),
  .rb_oe(rb_oe), .sr(sr), .store(store), .sel({sel_hi, sel_mid, sel_lo})
);

// File: tb/sim_cap_trim_ctrl.sv
module sim_cap_trim_ctrl;
  logic clk = 0, rst_n = 0, sclk = 0, sdat = 0, hv_pulse = 0;
  logic [1:0] sel_hi;
  logic [2:0] sel_mid;
  logic [4:0] sel_lo;
  logic rb_data, rb_oe;
  int ntot = 0, nfail = 0;

  cap_trim_ctrl u0 (.clk(clk), .rst_n(rst_n), .sclk(sclk), .sdat(sdat),
    .hv_pulse(hv_pulse), .sel_hi(sel_hi), .sel_mid(sel_mid), .sel_lo(sel_lo),
    .rb_data(rb_data), .rb_oe(rb_oe));

  always #10 clk = ~clk;

  localparam logic [10:0] VEC [6] = '{
    11'b00000010100, 11'b11111111110, 11'b10101010101,
    11'b01011100011, 11'b00000000001, 11'b11000000000 };

  task automatic chk(string tag, int act, int exp);
    ntot++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sel_word();
    return int'({sel_hi, sel_mid, sel_lo});
  endfunction

  function automatic int total_ff();
    return 6600 + 6400 * int'(sel_hi) + 1400 * int'(sel_mid) + 63 * int'(sel_lo);
  endfunction

  task automatic shift_word(logic [10:0] w);
    for (int i = 0; i < 11; i++) begin
      @(negedge clk); sclk = 0; sdat = w[i];
      @(negedge clk); sclk = 1;
    end
    @(negedge clk); #1;
  endtask

  task automatic pulse();
    @(negedge clk); hv_pulse = 1;
    @(negedge clk); hv_pulse = 0;
    @(negedge clk); #1;
  endtask

  task automatic go_low();
    @(negedge clk); sclk = 0; #1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    ntot++; nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R4 sel after reset", sel_word(), 0);
    chk("R4 rb_oe after reset", int'(rb_oe), 0);
    rst_n = 1;

    for (int v = 0; v < 6; v++) begin
      shift_word(VEC[v]);
      chk("R1 R2 live select", sel_word(), int'(VEC[v][10:1]));
    end
    go_low();
    chk("R3 R4 erased store selects none", sel_word(), 0);

    shift_word(11'b00000010100);
    chk("R9 low bank", int'(sel_lo), 10);
    chk("R9 total fF", total_ff(), 7230);

    shift_word(11'b11111111011); pulse();
    shift_word(11'b11111101111); pulse();
    go_low();
    chk("R6 R3 stored low bank", int'(sel_lo), 10);
    chk("R6 R3 stored high/mid", int'({sel_hi, sel_mid}), 0);
    chk("R9 stored total fF", total_ff(), 7230);

    shift_word(11'b11111111011);
    chk("R7 oe bit2", int'(rb_oe), 1);
    chk("R7 data bit2", int'(rb_data), 0);
    shift_word(11'b11111011111);
    chk("R7 oe bit5", int'(rb_oe), 1);
    chk("R7 data bit5", int'(rb_data), 1);
    @(negedge clk); sdat = 0; #1;
    chk("R7 oe with data low", int'(rb_oe), 0);

    @(negedge clk); hv_pulse = 1;
    shift_word(11'b11101111111);
    @(negedge clk); hv_pulse = 0; sclk = 0; #1;
    chk("R8 held pulse only one write", sel_word(), ((1 << 2) | (1 << 4) | (1 << 5)) >> 1);

    shift_word(11'b11111111111);
    chk("R7 no position chosen", int'(rb_oe), 0);
    pulse();
    go_low();
    chk("R5 erase selects none", sel_word(), 0);
    shift_word(11'b11111111110);
    chk("R5 check bit high after erase", int'(rb_data), 1);
    shift_word(11'b11111111011);
    chk("R5 bit2 high after erase", int'(rb_data), 1);

    finish_run();
  end
endmodule